// File: doc/BRIEF.md
# Interrupt Eligibility Mask Bank

This block keeps the per-line state of a bank of interrupt lines and turns it, every clock, into a mask. A set bit in the mask means that line may be offered to a processor interface. Each line has four pieces of state. A pending latch is set by software or by a rising edge on the line. Enable and active flags are set and cleared by software. Three configuration bits are driven from outside: edge or level triggering, the group bit, and the group modifier. The mask is worked out for the whole bank at once with bitwise logic, and there is no per-line loop.

A line counts as pending in either of two cases: its latch is set, or it is configured as level and its input is high right now. The line must also be enabled and not active. It must then pass a security group check. The group bit and the group modifier place the line in one of three classes, and each class has its own global enable. A global security-disable input makes every modifier read as zero. Choosing a winner among the eligible lines and routing it onward are left to downstream logic.

The set and clear inputs are write-one-to-act masks sampled on each clock, and they have no handshake. Nothing streams through the block: every input and output is a plain level or mask, so there is no back-pressure to manage.

Top module: `irq_elig_bank`

## Requirements
- R1: While reset is held and on the first clock after it is released, the mask is all zero; pending, enable and active state all reset to zero.
- R2: A line with its edge-config bit at 0 (level) counts as pending whenever its input is 1, without using the latch.
- R3: A line with its edge-config bit at 1 sets its pending latch when its input goes from 0 to 1 between two clocks, and the latch stays set after the input falls until a clear-pending bit removes it.
- R4: A pending line is eligible only while its enable flag is set; the set-enable and clear-enable masks write that flag.
- R5: A line whose active flag is set is never eligible; the set-active and clear-active masks write that flag.
- R6: A line whose group bit is 1 is in class "group 1 non-secure" and passes only while the non-secure group-1 enable input is 1.
- R7: A line with group bit 0 and modifier 1 is in class "group 1 secure" and passes only while the secure group-1 enable input is 1.
- R8: A line with group bit 0 and modifier 0 is in class "group 0" and passes only while the group-0 enable input is 1; with all three enables at 0 the mask is zero.
- R9: While the security-disable input is 1, every modifier bit is treated as 0.
- R10: For pending, enable and active, a clear bit and a set bit for the same line in the same cycle leave the flag cleared; for pending, a clear also wins over a rising edge in that cycle.
- R11: The mask is a register: a state change made at one clock edge shows up in the mask at the next clock edge, and a change on a level input shows up one clock later.
- R12: An edge-configured input that stays high does not set the latch again after it has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IRQ | Raw interrupt input lines |
| cfg_edge | input | NUM_IRQ | 1 = edge-triggered, 0 = level |
| cfg_grp | input | NUM_IRQ | Group bit per line |
| cfg_mod | input | NUM_IRQ | Group modifier per line |
| en_grp0 | input | 1 | Global enable for group 0 |
| en_grp1s | input | 1 | Global enable for secure group 1 |
| en_grp1ns | input | 1 | Global enable for non-secure group 1 |
| sec_dis | input | 1 | Security disable; forces modifiers to 0 |
| set_en | input | NUM_IRQ | Write-one set of enable flags |
| clr_en | input | NUM_IRQ | Write-one clear of enable flags |
| set_pend | input | NUM_IRQ | Write-one set of pending latches |
| clr_pend | input | NUM_IRQ | Write-one clear of pending latches |
| set_act | input | NUM_IRQ | Write-one set of active flags |
| clr_act | input | NUM_IRQ | Write-one clear of active flags |
| elig_mask | output | NUM_IRQ | Registered eligibility mask |

## Verification
The assertions take for granted that the configuration inputs and the global enables are held steady for at least two clocks around each observation. A clear or set applied to a line is judged two clocks later, which allows one clock to write the flag and one clock to register the mask. The bench changes group settings and configuration only between phases, then waits at least two clocks before it checks. Within a phase only the data-path inputs vary: the lines and the set and clear masks. During reset the bench holds every line low, so no rising edge is seen as the reset is released.

// File: rtl/irq_elig_pkg.sv
package irq_elig_pkg;
  // Global group gating controls, bundled so sub-blocks share one type.
  typedef struct packed {
    logic sec_dis;
    logic g0;
    logic g1s;
    logic g1ns;
  } grp_ctl_t;
endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [NUM_IRQ-1:0] cfg_edge,
  input  logic [NUM_IRQ-1:0] set_pend,
  input  logic [NUM_IRQ-1:0] clr_pend,
  output logic [NUM_IRQ-1:0] pend_q
);
  logic [NUM_IRQ-1:0] prev_q;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    logic rise;
    assign rise = cfg_edge[i] & irq_in[i] & ~prev_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        prev_q[i] <= irq_in[i];
        // clear wins over both software set and a detected edge
        pend_q[i] <= (pend_q[i] | set_pend[i] | rise) & ~clr_pend[i];
      end
    end
  end
endmodule

// File: rtl/irq_w1_flags.sv
module irq_w1_flags #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] set_m,
  input  logic [NUM_IRQ-1:0] clr_m,
  output logic [NUM_IRQ-1:0] flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q | set_m) & ~clr_m;
  end
endmodule

// File: rtl/irq_group_gate.sv
module irq_group_gate
  import irq_elig_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic [NUM_IRQ-1:0] cfg_grp,
  input  logic [NUM_IRQ-1:0] cfg_mod,
  input  grp_ctl_t           ctl,
  output logic [NUM_IRQ-1:0] allow
);
  logic [NUM_IRQ-1:0] mod_eff;
  logic [NUM_IRQ-1:0] cls_g1ns, cls_g1s, cls_g0;

  always_comb begin
    mod_eff  = ctl.sec_dis ? '0 : cfg_mod;
    cls_g1ns = cfg_grp;
    cls_g1s  = ~cfg_grp & mod_eff;
    cls_g0   = ~cfg_grp & ~mod_eff;
    allow    = ({NUM_IRQ{ctl.g1ns}} & cls_g1ns)
             | ({NUM_IRQ{ctl.g1s}}  & cls_g1s)
             | ({NUM_IRQ{ctl.g0}}   & cls_g0);
  end
endmodule

// File: rtl/irq_elig_bank.sv
module irq_elig_bank
  import irq_elig_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [NUM_IRQ-1:0] cfg_edge,
  input  logic [NUM_IRQ-1:0] cfg_grp,
  input  logic [NUM_IRQ-1:0] cfg_mod,
  input  logic               en_grp0,
  input  logic               en_grp1s,
  input  logic               en_grp1ns,
  input  logic               sec_dis,
  input  logic [NUM_IRQ-1:0] set_en,
  input  logic [NUM_IRQ-1:0] clr_en,
  input  logic [NUM_IRQ-1:0] set_pend,
  input  logic [NUM_IRQ-1:0] clr_pend,
  input  logic [NUM_IRQ-1:0] set_act,
  input  logic [NUM_IRQ-1:0] clr_act,
  output logic [NUM_IRQ-1:0] elig_mask
);
  logic [NUM_IRQ-1:0] pend_q, en_q, act_q, allow, pend_any, elig_d;
  grp_ctl_t           ctl;

  assign ctl = '{sec_dis: sec_dis, g0: en_grp0, g1s: en_grp1s, g1ns: en_grp1ns};

  irq_pend_latch #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_edge(cfg_edge),
    .set_pend(set_pend), .clr_pend(clr_pend), .pend_q(pend_q)
  );

  irq_w1_flags #(.NUM_IRQ(NUM_IRQ)) u_enable (
    .clk(clk), .rst_n(rst_n), .set_m(set_en), .clr_m(clr_en), .flag_q(en_q)
  );

  irq_w1_flags #(.NUM_IRQ(NUM_IRQ)) u_active (
    .clk(clk), .rst_n(rst_n), .set_m(set_act), .clr_m(clr_act), .flag_q(act_q)
  );

  irq_group_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
    .cfg_grp(cfg_grp), .cfg_mod(cfg_mod), .ctl(ctl), .allow(allow)
  );

  always_comb begin
    pend_any = pend_q | (irq_in & ~cfg_edge);
    elig_d   = pend_any & en_q & ~act_q & allow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) elig_mask <= '0;
    else        elig_mask <= elig_d;
  end
endmodule

// File: rtl/irq_elig_bank_chk.sv
module irq_elig_bank_chk #(
  parameter int NUM_IRQ = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en_grp0,
  input logic               en_grp1s,
  input logic               en_grp1ns,
  input logic [NUM_IRQ-1:0] clr_en,
  input logic [NUM_IRQ-1:0] set_act,
  input logic [NUM_IRQ-1:0] clr_act,
  input logic [NUM_IRQ-1:0] clr_pend,
  input logic [NUM_IRQ-1:0] set_pend,
  input logic [NUM_IRQ-1:0] irq_in,
  input logic [NUM_IRQ-1:0] cfg_edge,
  input logic [NUM_IRQ-1:0] elig_mask
);
  // First clock after reset release shows the reset mask.
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (elig_mask == '0));

  // A cleared enable removes the line two clocks on.
  p_clr_en_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en != '0) |-> ##2 ((elig_mask & $past(clr_en, 2)) == '0));

  // A line made active drops out two clocks on.
  p_active_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_act & ~clr_act) != '0) |-> ##2 ((elig_mask & $past(set_act & ~clr_act, 2)) == '0));

  // With every group enable off, nothing gets through.
  p_no_group_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_grp0 && !en_grp1s && !en_grp1ns) |=> (elig_mask == '0));

  // A clear-pending on an edge line with no fresh edge, steady low input,
  // and no set leaves it out of the mask two clocks on (R10).
  p_clr_pend_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_pend & cfg_edge & ~irq_in) != '0) ##1
    ((($past(clr_pend & cfg_edge & ~irq_in)) & (irq_in | set_pend)) == '0)
    |=> ((elig_mask & $past(clr_pend & cfg_edge & ~irq_in, 2)) == '0));
endmodule

bind irq_elig_bank irq_elig_bank_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_grp0(en_grp0), .en_grp1s(en_grp1s),
  .en_grp1ns(en_grp1ns), .clr_en(clr_en), .set_act(set_act), .clr_act(clr_act),
  .clr_pend(clr_pend), .set_pend(set_pend), .irq_in(irq_in),
  .cfg_edge(cfg_edge), .elig_mask(elig_mask)
);

// File: tb/irq_elig_bank_bench.sv
module irq_elig_bank_bench;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_in = '0, cfg_edge = '0, cfg_grp = '0, cfg_mod = '0;
  logic         en_grp0 = 1'b0, en_grp1s = 1'b0, en_grp1ns = 1'b0, sec_dis = 1'b0;
  logic [N-1:0] set_en = '0, clr_en = '0, set_pend = '0, clr_pend = '0;
  logic [N-1:0] set_act = '0, clr_act = '0;
  logic [N-1:0] elig_mask;

  always #10 clk = ~clk;  // 50 MHz

  irq_elig_bank #(.NUM_IRQ(N)) u_irq_elig_bank (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_edge(cfg_edge),
    .cfg_grp(cfg_grp), .cfg_mod(cfg_mod), .en_grp0(en_grp0),
    .en_grp1s(en_grp1s), .en_grp1ns(en_grp1ns), .sec_dis(sec_dis),
    .set_en(set_en), .clr_en(clr_en), .set_pend(set_pend),
    .clr_pend(clr_pend), .set_act(set_act), .clr_act(clr_act),
    .elig_mask(elig_mask)
  );

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  // Bench model of the state
  logic [N-1:0] m_pend = '0, m_en = '0, m_act = '0, m_prev = '0, m_exp = '0;

  function automatic logic [N-1:0] group_ok(logic [N-1:0] g, logic [N-1:0] m,
                                            logic sd, logic e0, logic e1s, logic e1ns);
    logic [N-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) begin
      logic mm;
      mm = sd ? 1'b0 : m[i];
      if (g[i])        r[i] = e1ns;
      else if (mm)     r[i] = e1s;
      else             r[i] = e0;
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    m_exp  = (m_pend | (irq_in & ~cfg_edge)) & m_en & ~m_act &
             group_ok(cfg_grp, cfg_mod, sec_dis, en_grp0, en_grp1s, en_grp1ns);
    m_pend = (m_pend | set_pend | (irq_in & ~m_prev & cfg_edge)) & ~clr_pend;
    m_en   = (m_en | set_en) & ~clr_en;
    m_act  = (m_act | set_act) & ~clr_act;
    m_prev = irq_in;
    @(negedge clk);
  endtask

  task automatic idle_ctl();
    set_en = '0; clr_en = '0; set_pend = '0; clr_pend = '0; set_act = '0; clr_act = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    chk("R1 mask in reset", elig_mask, '0);
    rst_n = 1'b1;
    tick();
    chk("R1 first clock after reset", elig_mask, '0);

    // R1: enable everything but nothing pending: state was zero
    en_grp0 = 1; en_grp1s = 1; en_grp1ns = 1;
    cfg_edge = '1;
    set_en = '1; tick(); idle_ctl(); tick();
    chk("R1 no pending after reset", elig_mask, '0);

    // R6 R7 R8 R9: group sweep; line i: grp=i[0], mod=i[1], level high
    cfg_edge = '0; cfg_grp = 32'hAAAA_AAAA; cfg_mod = 32'hCCCC_CCCC;
    irq_in = '1;
    for (int c = 0; c < 16; c++) begin
      {sec_dis, en_grp0, en_grp1s, en_grp1ns} = c[3:0];
      tick(); tick();
      chk($sformatf("R6 R7 R8 R9 group gate combo %0d", c), elig_mask,
          group_ok(cfg_grp, cfg_mod, c[3], c[2], c[1], c[0]));
      chk("R2 model", elig_mask, m_exp);
    end

    // R11: latency of a set-pending; level lines low
    irq_in = '0; en_grp0 = 1; en_grp1s = 1; en_grp1ns = 1; sec_dis = 0;
    cfg_edge = '1;
    tick(); tick();
    chk("R2 level low not pending", elig_mask, '0);
    set_pend = 32'h0000_0020; tick(); idle_ctl();
    chk("R11 mask not yet updated", elig_mask, '0);
    tick();
    chk("R11 mask after one more clock", elig_mask, 32'h0000_0020);

    // R10: clear beats set for pending, enable, active
    set_pend = 32'h0000_0100; clr_pend = 32'h0000_0120; tick(); idle_ctl(); tick();
    chk("R10 clear beats set pending", elig_mask, '0);
    set_pend = 32'h0000_0300; tick(); idle_ctl();
    set_en = 32'h0000_0100; clr_en = 32'h0000_0100; tick(); idle_ctl(); tick();
    chk("R10 R4 clear beats set enable", elig_mask, 32'h0000_0200);
    set_en = 32'h0000_0100; tick(); idle_ctl(); tick();
    chk("R4 re-enabled", elig_mask, 32'h0000_0300);
    set_act = 32'h0000_0300; clr_act = 32'h0000_0100; tick(); idle_ctl(); tick();
    chk("R10 R5 active blocks, clear beats set", elig_mask, 32'h0000_0100);
    clr_act = 32'h0000_0200; tick(); idle_ctl(); tick();
    chk("R5 active cleared", elig_mask, 32'h0000_0300);
    clr_pend = '1; tick(); idle_ctl(); tick();
    chk("R10 all pending cleared", elig_mask, '0);

    // R3 R12: edge latch
    irq_in = 32'h0001_0000; tick(); tick();
    chk("R3 rising edge latched", elig_mask, 32'h0001_0000);
    irq_in = '0; tick(); tick();
    chk("R3 latch held after fall", elig_mask, 32'h0001_0000);
    irq_in = 32'h0001_0000; clr_pend = 32'h0001_0000; tick(); idle_ctl(); tick(); tick();
    chk("R10 clear beats edge", elig_mask, '0);
    irq_in = 32'h0001_0000; tick(); tick(); tick();
    chk("R12 held-high input no re-latch", elig_mask, '0);
    irq_in = '0; tick();
    irq_in = 32'h0001_0000; tick(); tick();
    chk("R3 new edge latches again", elig_mask, 32'h0001_0000);
    irq_in = '0;

    // Pseudo-random phases against the model (R2 R3 R4 R5 R10 R11)
    lfsr = 32'h1ACE_B00C;
    for (int ph = 0; ph < 8; ph++) begin
      idle_ctl();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cfg_edge = lfsr;
      cfg_grp = {lfsr[15:0], lfsr[31:16]};
      cfg_mod = ~lfsr ^ {lfsr[7:0], lfsr[31:8]};
      {sec_dis, en_grp0, en_grp1s, en_grp1ns} = ph[3:0] ^ 4'b0111;
      tick(); tick();
      for (int k = 0; k < 60; k++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        irq_in   = lfsr ^ {lfsr[3:0], lfsr[31:4]};
        set_en   = lfsr & {lfsr[10:0], lfsr[31:11]};
        clr_en   = lfsr & ~{lfsr[5:0], lfsr[31:6]} & {lfsr[20:0], lfsr[31:21]};
        set_pend = ~lfsr & {lfsr[12:0], lfsr[31:13]};
        clr_pend = lfsr & {lfsr[17:0], lfsr[31:18]} & ~{lfsr[2:0], lfsr[31:3]};
        set_act  = lfsr & {lfsr[24:0], lfsr[31:25]} & {lfsr[8:0], lfsr[31:9]};
        clr_act  = ~lfsr & {lfsr[27:0], lfsr[31:28]};
        tick();
        chk("R2 R3 R4 R5 R10 R11 random model", elig_mask, m_exp);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule